// File: doc/BRIEF.md
# Boundary Scan Data Register Chain

This block is the boundary scan data register of a small device that has two input pins and four output pins. It sits on the serial path between the test data input and the test data output. Each input pin owns one scan cell. Each output pin owns two scan cells: a data cell followed by an enable cell. The ten cells form one serial chain. A separate controller supplies three strobes, one each for capture, shift and update. That controller also drives a two-bit test mode.

On a rising test-clock edge the chain does one of three things. It captures parallel levels, it shifts one bit toward the test data output, or it holds. These are the operations `OP_CAPTURE`, `OP_SHIFT` and `OP_HOLD`. Capture has priority over shift, and hold is chosen when neither strobe is active.

On a falling edge with the update strobe high, the chain is copied into a bank of update latches. The test mode decides three things:
- which cells are captured,
- whether the latches drive the pads or the core inputs,
- or whether pads and core simply pass straight through.

The mode values are `TM_NORMAL` = 00, `TM_EXTERNAL` = 01, `TM_INTERNAL` = 10 and `TM_NORMAL_ALT` = 11.

Top module: `bscan_chain`

## Requirements
- R1: The chain is 10 cells long. Cell index 0 is nearest the test data input. Counting from the input, the cells are: input pin 0, input pin 1, then output pins 0 to 3, each as a data cell followed by an enable cell. After ten shifts, the first bit shifted in is the bit presented at `tdo`.
- R2: While `rst_n` is low, every cell and every update latch takes its default: input cells 0, output pins 0 and 1 data/enable 0/0, output pin 2 data/enable 1/0, output pin 3 data/enable 0/1.
- R3: On a rising `tck` edge with `shift_dr` high and `capture_dr` low, each cell takes the value of its neighbour nearer the input, and cell 0 takes `tdi`.
- R4: `tdo` changes only on a falling `tck` edge. It then shows the value of cell 9, the enable cell of output pin 3.
- R5: In external test mode (`mode` = 01), a rising edge with `capture_dr` high loads the input cells from `pad_in`. The output cells are left unchanged.
- R6: In internal test mode (`mode` = 10), a rising edge with `capture_dr` high loads each output pin's data cell from `core_data` and its enable cell from `core_en`. The input cells are left unchanged.
- R7: In normal mode (`mode` = 00 or 11), a capture loads the input cells from `pad_in` and the output cells from `core_data` and `core_en`.
- R8: When `capture_dr` and `shift_dr` are both high, the capture is performed and no shift occurs.
- R9: On a falling `tck` edge with `update_dr` high, the update latches load the chain. With `update_dr` low, the latches hold. If shift and update are both high in one period, the latches receive the chain as it stands after that period's shift.
- R10: In external test mode, `pad_out[k]` and `pad_oe[k]` come from the data and enable latches of output pin k, and `core_in` equals `pad_in`. When `pad_oe[k]` is 0, pad k is tri-stated.
- R11: In internal test mode, `core_in[i]` comes from the latch of input cell i, while `pad_out` and `pad_oe` follow `core_data` and `core_en`.
- R12: In normal mode (00 or 11), `pad_out` = `core_data`, `pad_oe` = `core_en` and `core_in` = `pad_in`, whatever the latches hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset to the cell defaults |
| tdi | input | 1 | Serial data into cell 0 |
| capture_dr | input | 1 | Capture strobe, acted on at the rising edge |
| shift_dr | input | 1 | Shift strobe, acted on at the rising edge |
| update_dr | input | 1 | Update strobe, acted on at the falling edge |
| mode | input | 2 | 00/11 normal, 01 external test, 10 internal test |
| pad_in | input | 2 | Levels at the two input pins |
| core_data | input | 4 | Core output data for the four output pins |
| core_en | input | 4 | Core output enables for the four output pins |
| tdo | output | 1 | Serial data out from cell 9, changes on the falling edge |
| pad_out | output | 4 | Data driven toward the four output pins |
| pad_oe | output | 4 | Output enables of the four output pins |
| core_in | output | 2 | Levels delivered to the core from the input pins |

## Verification
Two pairs of operations can meet in the same test-clock period.

The first pair is capture and shift. The bench raises `capture_dr` and `shift_dr` together and then shifts the chain out. The `tdo` stream must show the captured pattern with no extra shift.

The second pair is shift and update. The bench raises `shift_dr` and `update_dr` in the same period while the chain holds a known pattern. In external mode, the pads must then show the post-shift contents on the falling edge of that very period.

A behavioural queue model in the bench is compared with every output on every cycle.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [1:0] {
        TM_NORMAL     = 2'b00,
        TM_EXTERNAL   = 2'b01,
        TM_INTERNAL   = 2'b10,
        TM_NORMAL_ALT = 2'b11
    } test_mode_e;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'b00,
        OP_CAPTURE = 2'b01,
        OP_SHIFT   = 2'b10
    } chain_op_e;

endpackage

// File: rtl/bscan_capture_sel.sv
module bscan_capture_sel
    import bscan_pkg::*;
#(
    parameter int N_IN  = 2,
    parameter int N_OUT = 4,
    localparam int LEN  = N_IN + 2 * N_OUT
) (
    input  test_mode_e         mode,
    input  logic [N_IN-1:0]    pad_in,
    input  logic [N_OUT-1:0]   core_data,
    input  logic [N_OUT-1:0]   core_en,
    input  logic [LEN-1:0]     chain_q,
    output logic [LEN-1:0]     cap_vec
);

    logic take_pins;
    logic take_core;

    always_comb begin
        unique case (mode)
            TM_EXTERNAL: begin
                take_pins = 1'b1;
                take_core = 1'b0;
            end
            TM_INTERNAL: begin
                take_pins = 1'b0;
                take_core = 1'b1;
            end
            TM_NORMAL, TM_NORMAL_ALT: begin
                take_pins = 1'b1;
                take_core = 1'b1;
            end
            default: begin
                take_pins = 1'b0;
                take_core = 1'b0;
            end
        endcase
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_in_cell
        assign cap_vec[i] = take_pins ? pad_in[i] : chain_q[i];
    end

    for (genvar k = 0; k < N_OUT; k++) begin : g_out_cell
        assign cap_vec[N_IN+2*k]   = take_core ? core_data[k] : chain_q[N_IN+2*k];
        assign cap_vec[N_IN+2*k+1] = take_core ? core_en[k]   : chain_q[N_IN+2*k+1];
    end

endmodule

// File: rtl/bscan_shift_chain.sv
module bscan_shift_chain
    import bscan_pkg::*;
#(
    parameter int             LEN     = 10,
    parameter logic [LEN-1:0] RST_VAL = '0
) (
    input  logic           tck,
    input  logic           rst_n,
    input  logic           capture_dr,
    input  logic           shift_dr,
    input  logic           tdi,
    input  logic [LEN-1:0] cap_vec,
    output logic [LEN-1:0] chain_q,
    output logic           tdo
);

    chain_op_e op;

    always_comb begin
        if (capture_dr)
            op = OP_CAPTURE;
        else if (shift_dr)
            op = OP_SHIFT;
        else
            op = OP_HOLD;
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= RST_VAL;
        end else begin
            unique case (op)
                OP_CAPTURE: chain_q <= cap_vec;
                OP_SHIFT:   chain_q <= {chain_q[LEN-2:0], tdi};
                OP_HOLD:    chain_q <= chain_q;
                default:    chain_q <= chain_q;
            endcase
        end
    end

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n)
            tdo <= RST_VAL[LEN-1];
        else
            tdo <= chain_q[LEN-1];
    end

endmodule

// File: rtl/bscan_update_stage.sv
module bscan_update_stage #(
    parameter int             LEN     = 10,
    parameter logic [LEN-1:0] RST_VAL = '0
) (
    input  logic           tck,
    input  logic           rst_n,
    input  logic           update_dr,
    input  logic [LEN-1:0] chain_q,
    output logic [LEN-1:0] upd_q
);

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n)
            upd_q <= RST_VAL;
        else if (update_dr)
            upd_q <= chain_q;
    end

endmodule

// File: rtl/bscan_pin_mux.sv
module bscan_pin_mux
    import bscan_pkg::*;
#(
    parameter int N_IN  = 2,
    parameter int N_OUT = 4,
    localparam int LEN  = N_IN + 2 * N_OUT
) (
    input  test_mode_e       mode,
    input  logic [LEN-1:0]   upd_q,
    input  logic [N_IN-1:0]  pad_in,
    input  logic [N_OUT-1:0] core_data,
    input  logic [N_OUT-1:0] core_en,
    output logic [N_OUT-1:0] pad_out,
    output logic [N_OUT-1:0] pad_oe,
    output logic [N_IN-1:0]  core_in
);

    logic drive_pads;
    logic drive_core;

    always_comb begin
        unique case (mode)
            TM_EXTERNAL: begin
                drive_pads = 1'b1;
                drive_core = 1'b0;
            end
            TM_INTERNAL: begin
                drive_pads = 1'b0;
                drive_core = 1'b1;
            end
            TM_NORMAL, TM_NORMAL_ALT: begin
                drive_pads = 1'b0;
                drive_core = 1'b0;
            end
            default: begin
                drive_pads = 1'b0;
                drive_core = 1'b0;
            end
        endcase
    end

    for (genvar k = 0; k < N_OUT; k++) begin : g_pad
        assign pad_out[k] = drive_pads ? upd_q[N_IN+2*k]   : core_data[k];
        assign pad_oe[k]  = drive_pads ? upd_q[N_IN+2*k+1] : core_en[k];
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_core
        assign core_in[i] = drive_core ? upd_q[i] : pad_in[i];
    end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int                        N_IN    = 2,
    parameter int                        N_OUT   = 4,
    parameter logic [N_IN+2*N_OUT-1:0]   RST_VAL = 10'b10_0100_0000
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             tdi,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic [1:0]       mode,
    input  logic [N_IN-1:0]  pad_in,
    input  logic [N_OUT-1:0] core_data,
    input  logic [N_OUT-1:0] core_en,
    output logic             tdo,
    output logic [N_OUT-1:0] pad_out,
    output logic [N_OUT-1:0] pad_oe,
    output logic [N_IN-1:0]  core_in
);

    localparam int LEN = N_IN + 2 * N_OUT;

    test_mode_e     mode_e;
    logic [LEN-1:0] cap_vec;
    logic [LEN-1:0] chain_q;
    logic [LEN-1:0] upd_q;

    assign mode_e = test_mode_e'(mode);

    bscan_capture_sel #(.N_IN(N_IN), .N_OUT(N_OUT)) u_cap (
        .mode      (mode_e),
        .pad_in    (pad_in),
        .core_data (core_data),
        .core_en   (core_en),
        .chain_q   (chain_q),
        .cap_vec   (cap_vec)
    );

    bscan_shift_chain #(.LEN(LEN), .RST_VAL(RST_VAL)) u_chain (
        .tck        (tck),
        .rst_n      (rst_n),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .tdi        (tdi),
        .cap_vec    (cap_vec),
        .chain_q    (chain_q),
        .tdo        (tdo)
    );

    bscan_update_stage #(.LEN(LEN), .RST_VAL(RST_VAL)) u_upd (
        .tck       (tck),
        .rst_n     (rst_n),
        .update_dr (update_dr),
        .chain_q   (chain_q),
        .upd_q     (upd_q)
    );

    bscan_pin_mux #(.N_IN(N_IN), .N_OUT(N_OUT)) u_mux (
        .mode      (mode_e),
        .upd_q     (upd_q),
        .pad_in    (pad_in),
        .core_data (core_data),
        .core_en   (core_en),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .core_in   (core_in)
    );

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
    parameter int N_IN  = 2,
    parameter int N_OUT = 4,
    parameter int LEN   = 10
) (
    input logic             tck,
    input logic             rst_n,
    input logic             tdi,
    input logic             capture_dr,
    input logic             shift_dr,
    input logic             update_dr,
    input logic [1:0]       mode,
    input logic [N_IN-1:0]  pad_in,
    input logic [N_OUT-1:0] core_data,
    input logic [N_OUT-1:0] core_en,
    input logic             tdo,
    input logic [N_OUT-1:0] pad_out,
    input logic [N_OUT-1:0] pad_oe,
    input logic [N_IN-1:0]  core_in,
    input logic [LEN-1:0]   chain_q,
    input logic [LEN-1:0]   upd_q
);

    // R3
    shift_moves_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (shift_dr && !capture_dr) |=> chain_q == {$past(chain_q[LEN-2:0]), $past(tdi)});

    // R5
    ext_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (capture_dr && mode == 2'b01) |=>
            (chain_q[N_IN-1:0] == $past(pad_in)) &&
            (chain_q[LEN-1:N_IN] == $past(chain_q[LEN-1:N_IN])));

    // R6
    int_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (capture_dr && mode == 2'b10) |=>
            (chain_q[N_IN-1:0] == $past(chain_q[N_IN-1:0])) &&
            (chain_q[N_IN] == $past(core_data[0])) &&
            (chain_q[N_IN+1] == $past(core_en[0])));

    // R4
    tdo_last_cell_chk: assert property (@(posedge tck) disable iff (!rst_n)
        tdo == chain_q[LEN-1]);

    // R9
    update_load_chk: assert property (@(negedge tck) disable iff (!rst_n)
        update_dr |=> upd_q == $past(chain_q));

    // R9
    update_hold_chk: assert property (@(negedge tck) disable iff (!rst_n)
        !update_dr |=> $stable(upd_q));

    // R12
    normal_pass_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (mode == 2'b00 || mode == 2'b11) |->
            (pad_out == core_data) && (pad_oe == core_en) && (core_in == pad_in));

    // R10
    ext_core_pass_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (mode == 2'b01) |-> core_in == pad_in);

endmodule

bind bscan_chain bscan_chain_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .LEN(LEN)) u_chk (
    .tck        (tck),
    .rst_n      (rst_n),
    .tdi        (tdi),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .mode       (mode),
    .pad_in     (pad_in),
    .core_data  (core_data),
    .core_en    (core_en),
    .tdo        (tdo),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .core_in    (core_in),
    .chain_q    (chain_q),
    .upd_q      (upd_q)
);

// File: tb/bscan_chain_test.sv
module bscan_chain_test;

    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       tdi = 1'b0;
    logic       capture_dr = 1'b0;
    logic       shift_dr = 1'b0;
    logic       update_dr = 1'b0;
    logic [1:0] mode = 2'b01;
    logic [1:0] pad_in = 2'b00;
    logic [3:0] core_data = 4'b0000;
    logic [3:0] core_en = 4'b0000;
    logic       tdo;
    logic [3:0] pad_out;
    logic [3:0] pad_oe;
    logic [1:0] core_in;

    always #5 tck = ~tck;

    bscan_chain uut (
        .tck(tck), .rst_n(rst_n), .tdi(tdi), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .mode(mode),
        .pad_in(pad_in), .core_data(core_data), .core_en(core_en),
        .tdo(tdo), .pad_out(pad_out), .pad_oe(pad_oe), .core_in(core_in)
    );

    int    vectors = 0;
    int    misses = 0;
    bit    done = 1'b0;
    string cur_tag = "R2";

    // Behavioural model: the chain is a queue, element 0 nearest tdi.
    bit q[$] = '{0, 0, 0, 0, 0, 0, 1, 0, 0, 1};
    bit u[10] = '{0, 0, 0, 0, 0, 0, 1, 0, 0, 1};
    bit tdo_m = 1'b1;

    always @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            q = '{0, 0, 0, 0, 0, 0, 1, 0, 0, 1};
        end else if (capture_dr) begin
            if (mode != 2'b10) begin
                q[0] = pad_in[0];
                q[1] = pad_in[1];
            end
            if (mode != 2'b01) begin
                for (int k = 0; k < 4; k++) begin
                    q[2+2*k] = core_data[k];
                    q[3+2*k] = core_en[k];
                end
            end
        end else if (shift_dr) begin
            q.push_front(tdi);
            void'(q.pop_back());
        end
    end

    always @(negedge tck or negedge rst_n) begin
        if (!rst_n) begin
            u = '{0, 0, 0, 0, 0, 0, 1, 0, 0, 1};
            tdo_m = 1'b1;
        end else begin
            if (update_dr)
                for (int i = 0; i < 10; i++) u[i] = q[i];
            tdo_m = q[9];
        end
    end

    task automatic chk(string tag, string what, int got, int exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    always @(posedge tck) begin
        #4;
        if (rst_n && !done) begin
            logic [3:0] e_po, e_oe;
            logic [1:0] e_ci;
            for (int k = 0; k < 4; k++) begin
                e_po[k] = (mode == 2'b01) ? u[2+2*k] : core_data[k];
                e_oe[k] = (mode == 2'b01) ? u[3+2*k] : core_en[k];
            end
            for (int i = 0; i < 2; i++)
                e_ci[i] = (mode == 2'b10) ? u[i] : pad_in[i];
            chk(cur_tag, "tdo", tdo, tdo_m);
            chk(cur_tag, "pad_out", pad_out, e_po);
            chk(cur_tag, "pad_oe", pad_oe, e_oe);
            chk(cur_tag, "core_in", core_in, e_ci);
        end
    end

    task automatic step(bit c, bit s, bit up, bit d);
        @(posedge tck);
        #1;
        capture_dr = c;
        shift_dr = s;
        update_dr = up;
        tdi = d;
    endtask

    task automatic load(logic [9:0] v);
        for (int i = 9; i >= 0; i--) step(0, 1, 0, v[i]);
    endtask

    task automatic drain();
        for (int i = 0; i < 10; i++) step(0, 1, 0, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        misses++;
        vectors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R2: reset defaults seen at the pads in external mode
        repeat (3) @(posedge tck);
        #1 rst_n = 1'b1;
        @(posedge tck);
        #4;
        chk("R2", "pad_out", pad_out, 4'b0100);
        chk("R2", "pad_oe", pad_oe, 4'b1000);
        cur_tag = "R2";
        drain();

        // R1 R3 R4: pattern travels from tdi to tdo
        cur_tag = "R1";
        load(10'b1100101101);
        cur_tag = "R3";
        drain();
        cur_tag = "R4";
        load(10'b0110011001);
        step(0, 0, 0, 0);

        // R9: update loads pads in external mode, then hold
        cur_tag = "R9";
        step(0, 0, 1, 0);
        step(0, 0, 0, 0);
        #4;
        chk("R9", "pad_out", pad_out, 4'b1010);
        load(10'b1111111111);
        step(0, 0, 0, 0);
        #4;
        chk("R9", "pad_out_hold", pad_out, 4'b1010);
        // R9: shift and update in the same period
        step(0, 1, 1, 0);
        step(0, 0, 0, 0);
        #4;
        chk("R9", "pad_oe_shift_upd", pad_oe, 4'b1111);
        chk("R9", "pad_out_shift_upd", pad_out, 4'b1111);

        // R10: external mode, pads from latches, core sees pins
        cur_tag = "R10";
        pad_in = 2'b01;
        core_data = 4'b0011;
        step(0, 0, 0, 0);
        pad_in = 2'b10;
        step(0, 0, 0, 0);
        #4;
        chk("R10", "core_in", core_in, 2'b10);

        // R5: external capture takes pins only
        cur_tag = "R5";
        load(10'b0000000000);
        pad_in = 2'b10;
        core_data = 4'b1111;
        core_en = 4'b1111;
        step(1, 0, 0, 0);
        drain();

        // R8: capture wins over shift
        cur_tag = "R8";
        pad_in = 2'b11;
        step(1, 1, 0, 1);
        drain();

        // R6: internal capture takes core outputs only
        cur_tag = "R6";
        mode = 2'b10;
        core_data = 4'b1010;
        core_en = 4'b0110;
        pad_in = 2'b01;
        load(10'b0000000011);
        step(1, 0, 0, 0);
        drain();

        // R11: internal update drives core inputs
        cur_tag = "R11";
        load(10'b0000000001);
        step(0, 0, 1, 0);
        step(0, 0, 0, 0);
        #4;
        chk("R11", "core_in", core_in, 2'b01);
        chk("R11", "pad_out", pad_out, 4'b1010);
        pad_in = 2'b10;
        step(0, 0, 0, 0);

        // R7: capture in both normal encodings
        cur_tag = "R7";
        mode = 2'b11;
        pad_in = 2'b01;
        core_data = 4'b0101;
        core_en = 4'b1001;
        step(1, 0, 0, 0);
        drain();
        mode = 2'b00;
        pad_in = 2'b10;
        core_data = 4'b1100;
        step(1, 0, 0, 0);
        drain();

        // R12: normal mode ignores latches
        cur_tag = "R12";
        load(10'b1111111111);
        step(0, 0, 1, 0);
        core_data = 4'b0110;
        core_en = 4'b0000;
        step(0, 0, 0, 0);
        #4;
        chk("R12", "pad_out", pad_out, 4'b0110);
        chk("R12", "pad_oe", pad_oe, 4'b0000);
        chk("R12", "core_in", core_in, 2'b10);
        mode = 2'b11;
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);

        finish_run();
    end

endmodule